// File: doc/BRIEF.md
# Endpoint Buffer Ownership Switch

This block holds a pool of packet buffers shared by a USB packet engine and a local I/O side. Data is never copied between them. A buffer passes from the side that fills it to the side that drains it when the filling side commits it, and it comes back when the draining side releases it. Each endpoint is a ring of one to four buffers. The ring has a direction:

- **OUT:** the USB side produces and the I/O side consumes.
- **IN:** the I/O side produces and the USB side consumes.

The USB side reaches the current buffer of its selected endpoint through one read/write port. The I/O side reaches the current buffer of its selected endpoint through two independent ports. Both sides can work in the same cycle on different buffers.

A configuration load sets, for each endpoint, whether it is enabled, its direction and its ring size. Rings are laid out back to back in the pool. Each side selects an endpoint, writes or reads words, and then commits or releases the whole buffer with a single pulse. A commit also stores the number of valid bytes, which the consumer sees later. Per-buffer ownership and per-endpoint empty and full flags are available at all times.

Top module: `ep_buffer_switch`

## Requirements
- R1: After reset no endpoint is active: `buf_io_own` is 0, `ep_empty` is all ones, `ep_full` is 0, and `usb_avail` and `io_avail` are 0.
- R2: `cfg_load` loads the endpoint settings and clears every ring pointer and every committed state.
  - `cfg_en` bit e enables endpoint e.
  - `cfg_dir_in` bit e set makes endpoint e an IN ring.
  - Field `cfg_size[2e+1:2e]` holds the ring size of endpoint e minus one.
  - Enabled endpoints take consecutive buffers, starting at buffer 0, in ascending endpoint order.
  - An enabled endpoint whose ring would extend past the last buffer stays inactive. An inactive endpoint ignores every request.
- R3: An uncommitted buffer belongs to its ring's producer. Bit b of `buf_io_own` is 1 when buffer b is I/O-owned. After a configuration, an OUT ring's buffers are USB-owned and an IN ring's buffers are I/O-owned.
- R4: A commit by the producer hands the buffer at the producer pointer to the consumer in the next cycle. The commit stores the byte count supplied with it. The producer pointer advances modulo the ring size.
- R5: A release by the consumer returns the buffer at the consumer pointer to the producer. The consumer pointer advances modulo the ring size, so buffers are drained in commit order.
- R6: `ep_empty[e]` is 1 when ring e has no committed buffer. `ep_full[e]` is 1 when every buffer of active ring e is committed. The two are never 1 together.
- R7: The following requests are ignored and leave ownership unchanged:
  - a commit or release while the side's `avail` is 0;
  - a commit from the consumer side or a release from the producer side;
  - any request on an inactive endpoint.
- R8: The USB port reads with one cycle of latency. It writes only when `usb_avail` is 1, and reads return 0 when `usb_avail` was 0.
- R9: Both I/O ports address the same current buffer, with one cycle of read latency. When both write the same word in one cycle, port A's data is kept. Writes and reads are blocked or return 0 when `io_avail` is 0.
- R10: On the consumer side of the selected endpoint, `usb_bytes_out` or `io_bytes_out` shows the byte count stored with the current buffer. It shows 0 when that side cannot access a committed buffer.
- R11: A commit by the producer and a release by the consumer of the same ring in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load endpoint configuration, clear pointers and ownership |
| cfg_en | input | NEP | Endpoint enable per endpoint |
| cfg_dir_in | input | NEP | 1 = IN ring, 0 = OUT ring |
| cfg_size | input | 2*NEP | Ring size minus one, two bits per endpoint |
| usb_ep | input | EW | Endpoint selected by the USB side |
| usb_addr | input | AW | USB word address |
| usb_we | input | 1 | USB write enable |
| usb_wdata | input | DW | USB write data |
| usb_rdata | output | DW | USB read data, one cycle after address |
| usb_avail | output | 1 | USB side may access the current buffer |
| usb_commit | input | 1 | USB producer commit (OUT ring) |
| usb_release | input | 1 | USB consumer release (IN ring) |
| usb_bytes_in | input | CW | Byte count stored on USB commit |
| usb_bytes_out | output | CW | Byte count of the buffer the USB side consumes |
| io_ep | input | EW | Endpoint selected by the I/O side |
| io_avail | output | 1 | I/O side may access the current buffer |
| io_commit | input | 1 | I/O producer commit (IN ring) |
| io_release | input | 1 | I/O consumer release (OUT ring) |
| io_bytes_in | input | CW | Byte count stored on I/O commit |
| io_bytes_out | output | CW | Byte count of the buffer the I/O side consumes |
| ioa_addr | input | AW | I/O port A word address |
| ioa_we | input | 1 | I/O port A write enable |
| ioa_wdata | input | DW | I/O port A write data |
| ioa_rdata | output | DW | I/O port A read data |
| iob_addr | input | AW | I/O port B word address |
| iob_we | input | 1 | I/O port B write enable |
| iob_wdata | input | DW | I/O port B write data |
| iob_rdata | output | DW | I/O port B read data |
| buf_io_own | output | NBUF | Per buffer: 1 = owned by the I/O side |
| ep_empty | output | NEP | Ring has no committed buffer |
| ep_full | output | NEP | Every buffer of the ring is committed |

## Verification
Two events can meet in one cycle on a single ring. The producer can commit a buffer in the same cycle that the consumer releases another. On an OUT ring this means a USB commit and an I/O release on the same edge.

The bench drives the case on a two-buffer ring that holds one committed buffer. Afterwards it expects the released buffer to be back with USB and the new one to be with I/O. It also expects the ring to be neither empty nor full, and the consumer to see the byte count from the new commit. Port A and port B writing the same I/O word in one cycle is a second collision, and the bench checks it by reading the word back.

// File: rtl/ep_buffer_switch.sv
module ep_buffer_switch #(
  parameter int NBUF  = 8,
  parameter int NEP   = 4,
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = (NEP > 1) ? $clog2(NEP) : 1,
  localparam int CW   = $clog2(2 * DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [NEP-1:0]    cfg_en,
  input  logic [NEP-1:0]    cfg_dir_in,
  input  logic [2*NEP-1:0]  cfg_size,
  input  logic [EW-1:0]     usb_ep,
  input  logic [AW-1:0]     usb_addr,
  input  logic              usb_we,
  input  logic [DW-1:0]     usb_wdata,
  output logic [DW-1:0]     usb_rdata,
  output logic              usb_avail,
  input  logic              usb_commit,
  input  logic              usb_release,
  input  logic [CW-1:0]     usb_bytes_in,
  output logic [CW-1:0]     usb_bytes_out,
  input  logic [EW-1:0]     io_ep,
  output logic              io_avail,
  input  logic              io_commit,
  input  logic              io_release,
  input  logic [CW-1:0]     io_bytes_in,
  output logic [CW-1:0]     io_bytes_out,
  input  logic [AW-1:0]     ioa_addr,
  input  logic              ioa_we,
  input  logic [DW-1:0]     ioa_wdata,
  output logic [DW-1:0]     ioa_rdata,
  input  logic [AW-1:0]     iob_addr,
  input  logic              iob_we,
  input  logic [DW-1:0]     iob_wdata,
  output logic [DW-1:0]     iob_rdata,
  output logic [NBUF-1:0]   buf_io_own,
  output logic [NEP-1:0]    ep_empty,
  output logic [NEP-1:0]    ep_full
);
  localparam int BW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int SW = BW + 2;

  logic [NEP-1:0]  en_q, dir_q;
  logic [1:0]      size_q [NEP];
  logic [1:0]      pp_q   [NEP];
  logic [1:0]      cp_q   [NEP];
  logic [NBUF-1:0] full_q;
  logic [CW-1:0]   cnt_q  [NBUF];
  logic [DW-1:0]   mem    [NBUF][DEPTH];

  logic [NEP-1:0]  act;
  logic [BW-1:0]   base [NEP];
  logic [2:0]      rn   [NEP];
  logic [BW-1:0]   pbuf [NEP];
  logic [BW-1:0]   cbuf [NEP];
  logic [NBUF-1:0] used;
  logic [EW-1:0]   buf_ep [NBUF];

  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    for (int e = 0; e < NEP; e++) begin
      rn[e]   = {1'b0, size_q[e]} + 3'd1;
      base[e] = acc[BW-1:0];
      act[e]  = en_q[e] && ((acc + SW'(rn[e])) <= SW'(NBUF));
      if (act[e]) acc = acc + SW'(rn[e]);
      pbuf[e] = base[e] + BW'(pp_q[e]);
      cbuf[e] = base[e] + BW'(cp_q[e]);
    end
  end

  always_comb begin
    for (int b = 0; b < NBUF; b++) begin
      used[b]   = 1'b0;
      buf_ep[b] = '0;
      for (int e = 0; e < NEP; e++) begin
        if (act[e] && (SW'(b) >= SW'(base[e])) && (SW'(b) < SW'(base[e]) + SW'(rn[e]))) begin
          used[b]   = 1'b1;
          buf_ep[b] = EW'(e);
        end
      end
      buf_io_own[b] = used[b] && (full_q[b] ^ dir_q[buf_ep[b]]);
    end
  end

  always_comb begin
    for (int e = 0; e < NEP; e++) begin
      logic [2:0] nf;
      nf = '0;
      for (int k = 0; k < 4; k++)
        if (act[e] && (k <= int'(size_q[e])) && full_q[base[e] + BW'(k)]) nf = nf + 3'd1;
      ep_empty[e] = (nf == 3'd0);
      ep_full[e]  = act[e] && (nf == rn[e]);
    end
  end

  wire          u_in  = dir_q[usb_ep];
  wire          i_in  = dir_q[io_ep];
  wire [BW-1:0] u_buf = u_in ? cbuf[usb_ep] : pbuf[usb_ep];
  wire [BW-1:0] i_buf = i_in ? pbuf[io_ep]  : cbuf[io_ep];

  assign usb_avail = act[usb_ep] && (u_in ? full_q[u_buf] : !full_q[u_buf]);
  assign io_avail  = act[io_ep]  && (i_in ? !full_q[i_buf] : full_q[i_buf]);

  wire u_commit_ok  = !cfg_load && usb_commit  && usb_avail && !u_in;
  wire u_release_ok = !cfg_load && usb_release && usb_avail &&  u_in;
  wire i_commit_ok  = !cfg_load && io_commit   && io_avail  &&  i_in;
  wire i_release_ok = !cfg_load && io_release  && io_avail  && !i_in;

  assign usb_bytes_out = (usb_avail && u_in)  ? cnt_q[u_buf] : '0;
  assign io_bytes_out  = (io_avail  && !i_in) ? cnt_q[i_buf] : '0;

  function automatic logic [1:0] step(input logic [1:0] p, input logic [1:0] sz);
    return (p == sz) ? 2'd0 : p + 2'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      dir_q  <= '0;
      full_q <= '0;
      for (int e = 0; e < NEP; e++) begin
        size_q[e] <= '0;
        pp_q[e]   <= '0;
        cp_q[e]   <= '0;
      end
      for (int b = 0; b < NBUF; b++) cnt_q[b] <= '0;
    end else if (cfg_load) begin
      en_q   <= cfg_en;
      dir_q  <= cfg_dir_in;
      full_q <= '0;
      for (int e = 0; e < NEP; e++) begin
        size_q[e] <= cfg_size[2*e +: 2];
        pp_q[e]   <= '0;
        cp_q[e]   <= '0;
      end
    end else begin
      for (int e = 0; e < NEP; e++) begin
        if ((u_commit_ok && usb_ep == EW'(e)) || (i_commit_ok && io_ep == EW'(e)))
          pp_q[e] <= step(pp_q[e], size_q[e]);
        if ((u_release_ok && usb_ep == EW'(e)) || (i_release_ok && io_ep == EW'(e)))
          cp_q[e] <= step(cp_q[e], size_q[e]);
      end
      if (u_commit_ok) begin
        full_q[u_buf] <= 1'b1;
        cnt_q[u_buf]  <= usb_bytes_in;
      end
      if (i_commit_ok) begin
        full_q[i_buf] <= 1'b1;
        cnt_q[i_buf]  <= io_bytes_in;
      end
      if (u_release_ok) full_q[u_buf] <= 1'b0;
      if (i_release_ok) full_q[i_buf] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (usb_we && usb_avail) mem[u_buf][usb_addr] <= usb_wdata;
    if (iob_we && io_avail)  mem[i_buf][iob_addr] <= iob_wdata;
    if (ioa_we && io_avail)  mem[i_buf][ioa_addr] <= ioa_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usb_rdata <= '0;
      ioa_rdata <= '0;
      iob_rdata <= '0;
    end else begin
      usb_rdata <= usb_avail ? mem[u_buf][usb_addr] : '0;
      ioa_rdata <= io_avail  ? mem[i_buf][ioa_addr] : '0;
      iob_rdata <= io_avail  ? mem[i_buf][iob_addr] : '0;
    end
  end
endmodule

// File: rtl/ep_buffer_switch_chk.sv
module ep_buffer_switch_chk #(
  parameter int NBUF = 8,
  parameter int NEP  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_load,
  input logic [NBUF-1:0] buf_io_own,
  input logic [NEP-1:0]  ep_empty,
  input logic [NEP-1:0]  ep_full,
  input logic            usb_avail,
  input logic            usb_commit,
  input logic            usb_release,
  input logic            io_avail,
  input logic            io_commit,
  input logic            io_release
);
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_full & ep_empty) == '0);

  assert_cfg_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (ep_full == '0) && (&ep_empty));

  assert_handover_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $countones(buf_io_own ^ $past(buf_io_own)) <= 2);

  assert_blocked_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && !(usb_avail && (usb_commit || usb_release)) &&
     !(io_avail && (io_commit || io_release))) |=> $stable(buf_io_own));
endmodule

bind ep_buffer_switch ep_buffer_switch_chk #(.NBUF(NBUF), .NEP(NEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .buf_io_own(buf_io_own),
  .ep_empty(ep_empty), .ep_full(ep_full),
  .usb_avail(usb_avail), .usb_commit(usb_commit), .usb_release(usb_release),
  .io_avail(io_avail), .io_commit(io_commit), .io_release(io_release)
);

// File: tb/ep_buffer_switch_bench.sv
module ep_buffer_switch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_load = 0;
  logic [3:0]  cfg_en = 0, cfg_dir_in = 0;
  logic [7:0]  cfg_size = 0;
  logic [1:0]  usb_ep = 0, io_ep = 0;
  logic [7:0]  usb_addr = 0, ioa_addr = 0, iob_addr = 0;
  logic        usb_we = 0, ioa_we = 0, iob_we = 0;
  logic [15:0] usb_wdata = 0, ioa_wdata = 0, iob_wdata = 0;
  logic [15:0] usb_rdata, ioa_rdata, iob_rdata;
  logic        usb_avail, io_avail;
  logic        usb_commit = 0, usb_release = 0, io_commit = 0, io_release = 0;
  logic [9:0]  usb_bytes_in = 0, io_bytes_in = 0, usb_bytes_out, io_bytes_out;
  logic [7:0]  buf_io_own;
  logic [3:0]  ep_empty, ep_full;

  int tests = 0, fails = 0;
  bit done = 0;

  ep_buffer_switch u_ep_buffer_switch (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_load = 0; usb_we = 0; ioa_we = 0; iob_we = 0;
    usb_commit = 0; usb_release = 0; io_commit = 0; io_release = 0;
  endtask

  task automatic t_reset();
    check("R1 own", buf_io_own, 8'h00);
    check("R1 empty", ep_empty, 4'hF);
    check("R1 full", ep_full, 4'h0);
    check("R1 avail", {usb_avail, io_avail}, 2'b00);
  endtask

  task automatic t_config();
    cfg_load = 1; cfg_en = 4'hF; cfg_dir_in = 4'b0010;
    cfg_size = {2'd3, 2'd0, 2'd2, 2'd1};
    tick(); idle();
    check("R3 initial own", buf_io_own, 8'b0001_1100);
    check("R2 empty after cfg", ep_empty, 4'hF);
    usb_ep = 3; io_ep = 3;
    #1 check("R2 unfit ring inactive", {usb_avail, io_avail}, 2'b00);
    usb_commit = 1; io_commit = 1;
    tick(); idle();
    check("R7 inactive request ignored", buf_io_own, 8'b0001_1100);
  endtask

  task automatic t_out_ring();
    usb_ep = 0; io_ep = 0;
    usb_addr = 5; usb_wdata = 16'hA0A0; usb_we = 1; tick(); idle();
    usb_commit = 1; usb_bytes_in = 100; tick(); idle();
    check("R4 first commit", buf_io_own, 8'b0001_1101);
    usb_wdata = 16'hB1B1; usb_we = 1; tick(); idle();
    usb_commit = 1; usb_bytes_in = 200; tick(); idle();
    check("R6 full", ep_full, 4'b0001);
    check("R6 empty", ep_empty, 4'b1110);
    check("R7 producer blocked", usb_avail, 1'b0);
    usb_commit = 1; usb_bytes_in = 9; tick(); idle();
    check("R7 commit on full ignored", buf_io_own, 8'b0001_1111);
    check("R10 first count", io_bytes_out, 10'd100);
    ioa_addr = 5; tick();
    check("R9 read first buffer", ioa_rdata, 16'hA0A0);
    io_release = 1; tick(); idle();
    check("R5 release order", buf_io_own, 8'b0001_1110);
    check("R10 second count", io_bytes_out, 10'd200);
    tick();
    check("R5 second buffer data", ioa_rdata, 16'hB1B1);
    io_release = 1; tick(); idle();
    check("R6 empty after drain", ep_empty[0], 1'b1);
    tick();
    check("R9 read blocked", ioa_rdata, 16'h0000);
    io_release = 1; tick(); idle();
    check("R7 release on empty ignored", buf_io_own, 8'b0001_1100);
    usb_wdata = 16'hC2C2; usb_we = 1; usb_commit = 1; usb_bytes_in = 50; tick(); idle();
    check("R4 wrap own", buf_io_own, 8'b0001_1101);
    check("R4 wrap count", io_bytes_out, 10'd50);
    tick();
    check("R4 wrap data", ioa_rdata, 16'hC2C2);
  endtask

  task automatic t_in_ring();
    io_ep = 1; usb_ep = 1;
    ioa_addr = 1; ioa_wdata = 16'h1111; ioa_we = 1;
    iob_addr = 2; iob_wdata = 16'h2222; iob_we = 1;
    tick(); idle();
    ioa_addr = 3; ioa_wdata = 16'hAAAA; ioa_we = 1;
    iob_addr = 3; iob_wdata = 16'hBBBB; iob_we = 1;
    tick(); idle();
    io_commit = 1; io_bytes_in = 512; tick(); idle();
    check("R3 IN commit to USB", buf_io_own, 8'b0001_1001);
    check("R10 usb count", usb_bytes_out, 10'd512);
    usb_addr = 1; tick();
    check("R9 port A write", usb_rdata, 16'h1111);
    usb_addr = 2; tick();
    check("R9 port B write", usb_rdata, 16'h2222);
    usb_addr = 3; tick();
    check("R9 port A wins", usb_rdata, 16'hAAAA);
    usb_release = 1; tick(); idle();
    check("R5 IN release", buf_io_own, 8'b0001_1101);
  endtask

  task automatic t_blocked_write();
    usb_ep = 2; io_ep = 2;
    usb_addr = 0; usb_wdata = 16'h5555; usb_we = 1; usb_commit = 1; usb_bytes_in = 2;
    tick(); idle();
    check("R4 single ring commit", buf_io_own, 8'b0011_1101);
    usb_wdata = 16'h9999; usb_we = 1; tick(); idle();
    check("R8 read blocked", usb_rdata, 16'h0000);
    ioa_addr = 0; tick();
    check("R8 write blocked", ioa_rdata, 16'h5555);
    io_release = 1; tick(); idle();
    check("R5 single ring release", buf_io_own, 8'b0001_1101);
  endtask

  task automatic t_same_cycle();
    usb_ep = 0; io_ep = 0;
    usb_commit = 1; usb_bytes_in = 7; io_release = 1;
    tick(); idle();
    check("R11 own", buf_io_own, 8'b0001_1110);
    check("R11 not full", ep_full[0], 1'b0);
    check("R11 not empty", ep_empty[0], 1'b0);
    check("R11 count", io_bytes_out, 10'd7);
  endtask

  task automatic t_wrong_side();
    usb_ep = 0; io_ep = 0;
    usb_release = 1; io_commit = 1; tick(); idle();
    check("R7 wrong side ignored", buf_io_own, 8'b0001_1110);
  endtask

  task automatic t_reconfig();
    cfg_load = 1; cfg_en = 4'hF; cfg_dir_in = 4'h0; cfg_size = 8'h00;
    tick(); idle();
    check("R2 reconfig own", buf_io_own, 8'h00);
    check("R2 reconfig empty", ep_empty, 4'hF);
    io_ep = 0;
    #1 check("R2 reconfig count", io_bytes_out, 10'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_config();
    t_out_ring();
    t_in_ring();
    t_blocked_write();
    t_same_cycle();
    t_wrong_side();
    t_reconfig();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule